// File: doc/BRIEF.md
# Three-Wire Serial Register Access Port

This block lets an external host read and write a small internal map of byte-wide registers over three signals. The signals are a serial clock, an active-low select and one shared data line. The pad ring builds that shared line from three pins: `spi_sdi` as the input, `spi_sdo` as the output, and `spi_sdo_en` as the enable for the output driver.

Every transaction opens with a 16-bit command word, always sent most significant bit first. The command carries the direction, a byte count and a 13-bit register address. One to four data bytes follow it. In a multibyte transfer the block steps the register address by one after each byte. A configuration bit at address 0 selects the bit order of the data bytes.

The host may raise select between bytes to pause a transaction. It may also hold select low and issue transactions back to back.

The serial pins are sampled by the block clock `clk`. They are taken to be already synchronous to it. The serial clock must stay at each level for at least one `clk` cycle.

Top module: `rspi_slave`

## Requirements
- R1: After reset, every register reads 0x00, data bytes use MSB-first order, and `spi_sdo_en` is low.
- R2: The first 16 serial-clock rising edges while select is low form the command word, most significant bit first. Bit 15 is the direction (1 = read, 0 = write), bits 14:13 hold the byte count minus one, and bits 12:0 hold the start address.
- R3: A transaction moves exactly count+1 bytes of 8 bits each. The next rising edge after the last bit starts a new command, so select may stay low across back-to-back transactions.
- R4: Write data is sampled on serial-clock rising edges. Each complete byte is stored at the current address when that address is below NUM_REGS (addresses 0 to NUM_REGS-1 are mapped).
- R5: Read data is launched on serial-clock falling edges. The first data bit is presented after the falling edge that follows the 16th command bit, and each later falling edge presents the next bit.
- R6: `spi_sdo_en` is high only while select is low during the data phase of a read, from the first launching falling edge until the last data bit has been sampled.
- R7: After each byte the address changes by one, wrapping modulo 2^13. It decreases in MSB-first order and increases in LSB-first order.
- R8: Bit 0 of the register at address 0 selects LSB-first order for data bytes when set. The command word stays MSB-first in both orders. The order is captured when the command completes and holds for the whole transaction.
- R9: While select is high, serial-clock edges are ignored and all transaction state holds. The transaction resumes at the same bit once select falls again.
- R10: Writes to addresses at or above NUM_REGS change no register, and reads from them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select; high pauses the transaction |
| spi_sclk | input | 1 | Serial clock, synchronous to clk |
| spi_sdi | input | 1 | Data line as seen by the input buffer |
| spi_sdo | output | 1 | Read data to drive onto the data line |
| spi_sdo_en | output | 1 | Output enable for the data-line driver |

## Verification
The assertions assume that select, serial clock and input data change only on block-clock boundaries. They also assume each serial-clock level lasts at least one block cycle, so a rising and a falling edge never fall in the same cycle. The stimulus meets this by changing every serial pin on the falling edge of `clk` and holding each serial-clock level for two cycles. Before any pause, the stimulus waits for the falling edge that launches the next read bit, then raises select. The serial clock is toggled while paused to show that those edges are discarded.

// File: rtl/rspi_pkg.sv
package rspi_pkg;
  localparam int CMD_W  = 16;
  localparam int ADDR_W = 13;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/rspi_edge.sv
module rspi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  // edges only count while the port is selected
  assign rise = !cs_n &&  sclk && !sclk_q;
  assign fall = !cs_n && !sclk &&  sclk_q;
endmodule

// File: rtl/rspi_regfile.sv
module rspi_regfile
  import rspi_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              lsb_first
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);

  logic [NUM_REGS-1:0][BYTE_W-1:0] regs;
  logic wr_hit, rd_hit;

  assign wr_hit = wr_addr < LIMIT;
  assign rd_hit = rd_addr < LIMIT;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i)) q <= wr_data;
    end
    assign regs[i] = q;
  end

  assign rd_data   = rd_hit ? regs[rd_addr[IDX_W-1:0]] : '0;
  assign lsb_first = regs[0][0];

  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit) |=> $stable(regs)); // R10
endmodule

// File: rtl/rspi_engine.sv
module rspi_engine
  import rspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic              rise,
  input  logic              fall,
  input  logic              lsb_cfg,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_en
);
  localparam logic [3:0] CMD_LAST  = 4'(CMD_W - 1);
  localparam logic [3:0] BYTE_LAST = 4'(BYTE_W - 1);

  phase_e            phase;
  logic [3:0]        bit_cnt;
  logic [CMD_W-2:0]  cmd_sh;
  logic              is_read;
  logic [CNT_W-1:0]  bytes_left;
  logic [ADDR_W-1:0] addr;
  logic              lsb_lat;
  logic [BYTE_W-1:0] tx, rx;
  logic              drive, sdo_q;

  logic [CMD_W-1:0]  cmd_next;
  logic [BYTE_W-1:0] rx_next;
  logic [ADDR_W-1:0] addr_step;
  logic              byte_done;

  assign cmd_next  = {cmd_sh, sdi};
  assign rx_next   = lsb_lat ? {sdi, rx[BYTE_W-1:1]} : {rx[BYTE_W-2:0], sdi};
  assign addr_step = lsb_lat ? addr + 1'b1 : addr - 1'b1;
  assign rd_addr   = (phase == PH_CMD) ? cmd_next[ADDR_W-1:0] : addr_step;
  assign byte_done = rise && phase == PH_DATA && bit_cnt == BYTE_LAST;

  assign wr_en   = byte_done && !is_read;
  assign wr_addr = addr;
  assign wr_data = rx_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_CMD;
      bit_cnt    <= '0;
      cmd_sh     <= '0;
      is_read    <= 1'b0;
      bytes_left <= '0;
      addr       <= '0;
      lsb_lat    <= 1'b0;
      tx         <= '0;
      rx         <= '0;
      drive      <= 1'b0;
      sdo_q      <= 1'b0;
    end else if (rise) begin
      if (phase == PH_CMD) begin
        cmd_sh <= cmd_next[CMD_W-2:0];
        if (bit_cnt == CMD_LAST) begin
          phase      <= PH_DATA;
          bit_cnt    <= '0;
          is_read    <= cmd_next[CMD_W-1];
          bytes_left <= cmd_next[ADDR_W+CNT_W-1:ADDR_W];
          addr       <= cmd_next[ADDR_W-1:0];
          lsb_lat    <= lsb_cfg;
          tx         <= rd_data;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else begin
        rx <= rx_next;
        if (bit_cnt == BYTE_LAST) begin
          bit_cnt <= '0;
          addr    <= addr_step;
          tx      <= rd_data;
          if (bytes_left == '0) begin
            phase <= PH_CMD;
            drive <= 1'b0;
          end else begin
            bytes_left <= bytes_left - 1'b1;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end else if (fall && phase == PH_DATA && is_read) begin
      sdo_q <= lsb_lat ? tx[0] : tx[BYTE_W-1];
      tx    <= lsb_lat ? {1'b0, tx[BYTE_W-1:1]} : {tx[BYTE_W-2:0], 1'b0};
      drive <= 1'b1;
    end
  end

  assign sdo    = sdo_q;
  assign sdo_en = drive && !cs_n;

  AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> (phase == PH_DATA && is_read)); // R6
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(phase) && $stable(bit_cnt) && $stable(addr) && $stable(bytes_left))); // R9
  AST_ORDER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && $past(phase == PH_DATA)) |-> $stable(lsb_lat)); // R8
  AST_DATA_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA) |-> (bit_cnt <= BYTE_LAST)); // R3
  AST_LAUNCH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdo_q)); // R5
endmodule

// File: rtl/rspi_slave.sv
module rspi_slave
  import rspi_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sclk,
  input  logic spi_sdi,
  output logic spi_sdo,
  output logic spi_sdo_en
);
  logic              rise, fall, lsb_cfg, wr_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [BYTE_W-1:0] rd_data, wr_data;

  rspi_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .cs_n (spi_cs_n),
    .sclk (spi_sclk),
    .rise (rise),
    .fall (fall)
  );

  rspi_engine u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (spi_cs_n),
    .sdi    (spi_sdi),
    .rise   (rise),
    .fall   (fall),
    .lsb_cfg(lsb_cfg),
    .rd_data(rd_data),
    .rd_addr(rd_addr),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .sdo    (spi_sdo),
    .sdo_en (spi_sdo_en)
  );

  rspi_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .lsb_first(lsb_cfg)
  );

  AST_NO_DRIVE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n)) |-> !spi_sdo_en); // R6
endmodule

// File: tb/rspi_slave_tb.sv
module rspi_slave_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en;
  int total = 0, bad = 0;
  logic [7:0] model [8];
  logic [7:0] wdata [4];

  always #4 clk = ~clk;

  rspi_slave #(.NUM_REGS(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
    .spi_sdi(sdi), .spi_sdo(sdo), .spi_sdo_en(sdo_en)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic o, output logic oe);
    sdi = b;
    repeat (2) @(negedge clk);
    o = sdo; oe = sdo_en;
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic pause_port();
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      sdi = k[0];
      sclk = 1'b1; repeat (2) @(negedge clk);
      chk("R9", "driver off while paused", {31'd0, sdo_en}, 32'd0);
      sclk = 1'b0; repeat (2) @(negedge clk);
    end
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input string tag, input bit rd, input int w, input logic [12:0] a,
                      input bit pause_en, input bit keep_cs, input bit keep_mode);
    logic o, oe, lsb;
    logic [12:0] cur;
    logic [15:0] cmd;
    logic [7:0] got, exp_b, wb;
    lsb = model[0][0];
    cs_n = 1'b0;
    @(negedge clk);
    cmd = {rd, 2'(w), a};
    for (int i = 15; i >= 0; i--) begin
      bit_io(cmd[i], o, oe);
      if (i == 15) chk("R6", "driver off in command", {31'd0, oe}, 32'd0);
    end
    cur = a;
    for (int b = 0; b <= w; b++) begin
      if (pause_en && b > 0) pause_port();
      if (rd) begin
        exp_b = (cur < 13'd8) ? model[cur[2:0]] : 8'h00;
        got = '0;
        for (int k = 0; k < 8; k++) begin
          bit_io(1'b0, o, oe);
          got[lsb ? k : 7 - k] = o;
          if (k == 0) chk("R6", "driver on in read data", {31'd0, oe}, 32'd1);
        end
        chk(tag, "read byte", {24'd0, got}, {24'd0, exp_b});
      end else begin
        wb = wdata[b];
        if (keep_mode && cur == 13'd0) wb[0] = lsb;
        for (int k = 0; k < 8; k++) begin
          bit_io(wb[lsb ? k : 7 - k], o, oe);
          if (k == 0) chk("R6", "driver off in write data", {31'd0, oe}, 32'd0);
        end
        if (cur < 13'd8) model[cur[2:0]] = wb;
      end
      cur = lsb ? cur + 13'd1 : cur - 13'd1;
    end
    if (!keep_cs) begin
      repeat (2) @(negedge clk);
      chk("R6", "driver off after frame", {31'd0, sdo_en}, 32'd0);
      cs_n = 1'b1;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic fill(input int seed);
    for (int b = 0; b < 4; b++) wdata[b] = 8'((seed * 37) + (b * 91) + 8'h5B);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "driver off after reset", {31'd0, sdo_en}, 32'd0);
    // R1: every register reads zero after reset
    for (int a = 0; a < 8; a++) xfer("R1", 1'b1, 0, 13'(a), 1'b0, 1'b0, 1'b0);

    // R4 R7 R2: MSB-first write/read sweep over count and start address
    for (int w = 0; w < 4; w++)
      for (int a = 0; a < 8; a++) begin
        fill(w * 8 + a);
        xfer("R4", 1'b0, w, 13'(a), 1'b0, 1'b0, 1'b1);
        xfer("R2/R5/R7", 1'b1, w, 13'(a), 1'b0, 1'b0, 1'b0);
      end

    // R10: unmapped writes ignored, unmapped reads zero
    fill(99);
    xfer("R10", 1'b0, 1, 13'h1ABC, 1'b0, 1'b0, 1'b1);
    xfer("R10", 1'b1, 1, 13'h1ABC, 1'b0, 1'b0, 1'b0);
    xfer("R10", 1'b1, 3, 13'd7, 1'b0, 1'b0, 1'b0);

    // R8: order switch written mid-frame applies only from the next frame
    wdata[0] = 8'hA5; wdata[1] = 8'h01;
    xfer("R8", 1'b0, 1, 13'd1, 1'b0, 1'b0, 1'b0);
    xfer("R8", 1'b1, 3, 13'd0, 1'b0, 1'b0, 1'b0);

    // R9 R8: LSB-first sweep with pauses between bytes
    for (int w = 0; w < 4; w++)
      for (int a = 0; a < 8; a++) begin
        fill(w * 5 + a + 40);
        xfer("R9", 1'b0, w, 13'(a), 1'b1, 1'b0, 1'b1);
        xfer("R8/R9", 1'b1, w, 13'(a), 1'b1, 1'b0, 1'b0);
      end

    // R3: back-to-back frames with select held low
    fill(7);
    xfer("R3", 1'b0, 2, 13'd5, 1'b0, 1'b1, 1'b1);
    xfer("R3", 1'b1, 2, 13'd5, 1'b0, 1'b1, 1'b0);
    xfer("R3", 1'b1, 0, 13'd1, 1'b0, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule